// File: doc/BRIEF.md
# SWD memory-access sequencer

This block stands between a command port and a bit-level serial-wire-debug transfer engine. It turns four commands into fixed, ordered chains of engine jobs: connect, debug power-up, a single 32-bit memory write, and a burst of 32-bit memory reads. Each engine job is one of three kinds. It can be a line reset (the data line is held high for a set number of clocks, then low for 16), a run of idle clocks, or one debug-port or access-port register transfer with a trailing-clock count. The sequencer starts one job at a time and waits for the engine's completion pulse before it moves on.

A memory access always sets up the access port in the same way. It clears sticky errors, selects bank 0, programs the control/status word for 32-bit auto-incrementing accesses, and writes the target address. A write then moves the value through the data register and flushes it with a read-buffer read. A read burst keeps reading the data register. Because access-port reads are posted, the first good result is dropped. Each later good result is presented as one word, in ascending address order. A WAIT answer repeats the same transfer. Any other non-OK answer ends the command with an error.

Top module: `swd_mem_seq`

## Requirements
- R1: After reset, cmdReady is 1 and xferStart, rdValid and opDone are 0.
- R2: Connect (cmdOp 0) issues, in order: a line reset (xferKind 1) of 56 high clocks, two line resets of 59, 16 idle clocks (xferKind 2), then a debug-port read (xferKind 0, xferApnDp 0, xferRnw 1) at xferA 0 with xferCount 6.
- R3: Debug power-up (cmdOp 1) issues a debug-port write of 0x0000001E at xferA 0, then a debug-port write of 0x50000000 at xferA 1, each with xferCount 7.
- R4: Memory write (cmdOp 2) issues the setup chain, which is debug-port writes of 0x0000001E at xferA 0 (count 7) and 0 at xferA 2 (count 0), then access-port (xferApnDp 1) writes of 0x23000012 at xferA 0 and of cmdAddr at xferA 1 (count 0). It then issues an access-port write of cmdWdata at xferA 3 (count 7) and a debug-port read at xferA 3 (count 3).
- R5: Read burst (cmdOp 3) issues the setup chain of R4 once. It then issues only access-port reads at xferA 3 with count 3, and never rewrites the address.
- R6: In a burst, the first data read answered OK (xferAck 3'b001) yields no word. Each later OK read presents its xferRdata on rdData with rdValid high for one cycle, the cycle after its completion. A burst of N words issues N+1 OK reads.
- R7: A transfer answered WAIT (xferAck 3'b010) is issued again, unchanged, as the next job. It consumes no burst length.
- R8: A transfer answered with anything other than OK or WAIT (e.g. FAULT 3'b100) ends the command: opDone and opError pulse together the next cycle, and no further job starts.
- R9: xferStart is a one-cycle pulse. Only one job is outstanding at a time, and every job field holds steady from xferStart until xferDone.
- R10: opDone pulses for one cycle after the last job completes, with cmdReady high again. A cmdValid received while cmdReady is low has no effect.
- R11: A read burst with cmdLen 0 ends after the setup chain, with no data reads and no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, taken when cmdReady is high |
| cmdReady | output | 1 | Sequencer idle and able to take a command |
| cmdOp | input | 2 | 0 connect, 1 debug power-up, 2 memory write, 3 read burst |
| cmdAddr | input | 32 | Target memory address |
| cmdWdata | input | 32 | Value for a memory write |
| cmdLen | input | LEN_W | Number of words for a read burst |
| rdValid | output | 1 | Read word strobe |
| rdData | output | 32 | Read word |
| opDone | output | 1 | Command finished (one-cycle pulse) |
| opError | output | 1 | Command ended by an error answer (with opDone) |
| xferStart | output | 1 | Starts one engine job |
| xferKind | output | 2 | 0 register transfer, 1 line reset, 2 idle clocks |
| xferApnDp | output | 1 | 1 access port, 0 debug port |
| xferRnw | output | 1 | 1 read, 0 write |
| xferA | output | 2 | Register address bits [3:2] |
| xferWdata | output | 32 | Write data for the transfer |
| xferCount | output | CNT_W | Trailing clocks, reset length or idle clocks |
| xferDone | input | 1 | Engine job completed (one-cycle pulse) |
| xferAck | input | 3 | Acknowledge of a register transfer |
| xferRdata | input | 32 | Read data of a register transfer |

## Verification
The checks assume that the engine answers each xferStart with exactly one xferDone pulse at least a cycle later. They also assume that xferAck and xferRdata are valid only in that pulse and that xferDone never arrives with nothing outstanding. The bench engine model keeps to this: it takes a job only when idle, and it holds its latency at three cycles. It answers from a scripted list of acknowledges, and answers OK when the list is empty. Commands are offered only while cmdReady is high, except in the one case that checks that a busy sequencer ignores them.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

  typedef enum logic [1:0] {
    OP_CONNECT = 2'd0,
    OP_DEBUG   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_READ    = 2'd3
  } opcode_t;

  typedef enum logic [1:0] {
    XK_XFER    = 2'd0,
    XK_LINERST = 2'd1,
    XK_IDLE    = 2'd2
  } xkind_t;

  typedef enum logic [3:0] {
    ST_LR0, ST_LR1, ST_LR2, ST_IDLE, ST_IDCODE,
    ST_DBG_ABORT, ST_DBG_CTRL,
    ST_ABORT, ST_SELECT, ST_CSW, ST_TAR,
    ST_DRW_WR, ST_RDBUFF, ST_DRW_RD, ST_END
  } step_t;

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_BUSY} fsm_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadCmd;
    logic dropFirst;
    logic consumeWord;
  } strobe_t;

  localparam logic [2:0] ACK_OK   = 3'b001;
  localparam logic [2:0] ACK_WAIT = 3'b010;

  localparam logic [31:0] ABORT_CLEAR = 32'h0000_001E;
  localparam logic [31:0] PWR_UP_REQ  = 32'h5000_0000;
  localparam logic [31:0] CSW_WORD32  = 32'h2300_0012;

  localparam int RST_FIRST  = 56;
  localparam int RST_NEXT   = 59;
  localparam int IDLE_CLKS  = 16;
  localparam int TRL_IDCODE = 6;
  localparam int TRL_WRITE  = 7;
  localparam int TRL_READ   = 3;

endpackage

// File: rtl/swd_seq_ctrl.sv
module swd_seq_ctrl
  import swd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       xferDone,
  input  logic [2:0] xferAck,
  input  logic       lenZero,
  input  logic       lenOne,
  input  logic       firstPending,
  output logic       cmdReady,
  output logic       xferStart,
  output logic       opDone,
  output logic       opError,
  output step_t      step,
  output strobe_t    strb
);

  fsm_t    state;
  opcode_t opReg;
  step_t   nextS;
  step_t   firstS;
  logic    isXfer;
  logic    ackOk;
  logic    ackWait;
  logic    accept;

  assign cmdReady  = (state == F_IDLE);
  assign xferStart = (state == F_ISSUE);
  assign isXfer    = !(step inside {ST_LR0, ST_LR1, ST_LR2, ST_IDLE});
  assign ackOk     = (xferAck == ACK_OK);
  assign ackWait   = (xferAck == ACK_WAIT);
  assign accept    = (state == F_BUSY) && xferDone && (!isXfer || ackOk);

  always_comb begin
    case (opcode_t'(cmdOp))
      OP_CONNECT: firstS = ST_LR0;
      OP_DEBUG:   firstS = ST_DBG_ABORT;
      default:    firstS = ST_ABORT;
    endcase
  end

  always_comb begin
    case (step)
      ST_LR0:       nextS = ST_LR1;
      ST_LR1:       nextS = ST_LR2;
      ST_LR2:       nextS = ST_IDLE;
      ST_IDLE:      nextS = ST_IDCODE;
      ST_DBG_ABORT: nextS = ST_DBG_CTRL;
      ST_ABORT:     nextS = ST_SELECT;
      ST_SELECT:    nextS = ST_CSW;
      ST_CSW:       nextS = ST_TAR;
      ST_TAR:       nextS = (opReg == OP_WRITE) ? ST_DRW_WR : ST_DRW_RD;
      ST_DRW_WR:    nextS = ST_RDBUFF;
      default:      nextS = ST_END;
    endcase
  end

  always_comb begin
    strb             = '0;
    strb.loadCmd     = cmdReady && cmdValid;
    strb.dropFirst   = accept && (step == ST_DRW_RD) && firstPending;
    strb.consumeWord = accept && (step == ST_DRW_RD) && !firstPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= F_IDLE;
      opReg   <= OP_CONNECT;
      step    <= ST_END;
      opDone  <= 1'b0;
      opError <= 1'b0;
    end else begin
      opDone  <= 1'b0;
      opError <= 1'b0;
      case (state)
        F_IDLE: begin
          if (cmdValid) begin
            opReg <= opcode_t'(cmdOp);
            step  <= firstS;
            state <= F_ISSUE;
          end
        end
        F_ISSUE: state <= F_BUSY;
        default: begin
          if (xferDone) begin
            if (isXfer && ackWait) begin
              state <= F_ISSUE;
            end else if (isXfer && !ackOk) begin
              state   <= F_IDLE;
              opDone  <= 1'b1;
              opError <= 1'b1;
            end else if (step == ST_DRW_RD) begin
              if (!firstPending && lenOne) begin
                state  <= F_IDLE;
                opDone <= 1'b1;
              end else begin
                state <= F_ISSUE;
              end
            end else if (nextS == ST_END ||
                         (step == ST_TAR && opReg == OP_READ && lenZero)) begin
              state  <= F_IDLE;
              opDone <= 1'b1;
            end else begin
              step  <= nextS;
              state <= F_ISSUE;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/swd_seq_dp.sv
module swd_seq_dp
  import swd_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  step_t            step,
  input  logic [31:0]      cmdAddr,
  input  logic [31:0]      cmdWdata,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [31:0]      xferRdata,
  output logic             lenZero,
  output logic             lenOne,
  output logic             firstPending,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic [1:0]       xferKind,
  output logic             xferApnDp,
  output logic             xferRnw,
  output logic [1:0]       xferA,
  output logic [31:0]      xferWdata,
  output logic [CNT_W-1:0] xferCount
);

  logic [31:0]      addrReg;
  logic [31:0]      wdataReg;
  logic [LEN_W-1:0] lenReg;

  assign lenZero = (lenReg == '0);
  assign lenOne  = (lenReg == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg      <= '0;
      wdataReg     <= '0;
      lenReg       <= '0;
      firstPending <= 1'b0;
      rdValid      <= 1'b0;
      rdData       <= '0;
    end else begin
      rdValid <= strb.consumeWord;
      if (strb.loadCmd) begin
        addrReg      <= cmdAddr;
        wdataReg     <= cmdWdata;
        lenReg       <= cmdLen;
        firstPending <= 1'b1;
      end
      if (strb.dropFirst) firstPending <= 1'b0;
      if (strb.consumeWord) begin
        lenReg <= lenReg - LEN_W'(1);
        rdData <= xferRdata;
      end
    end
  end

  // Job field decode per step
  always_comb begin
    xferKind  = XK_XFER;
    xferApnDp = 1'b0;
    xferRnw   = 1'b0;
    xferA     = 2'd0;
    xferWdata = '0;
    xferCount = '0;
    case (step)
      ST_LR0: begin xferKind = XK_LINERST; xferCount = CNT_W'(RST_FIRST); end
      ST_LR1, ST_LR2: begin xferKind = XK_LINERST; xferCount = CNT_W'(RST_NEXT); end
      ST_IDLE: begin xferKind = XK_IDLE; xferCount = CNT_W'(IDLE_CLKS); end
      ST_IDCODE: begin xferRnw = 1'b1; xferCount = CNT_W'(TRL_IDCODE); end
      ST_DBG_ABORT, ST_ABORT: begin
        xferWdata = ABORT_CLEAR; xferCount = CNT_W'(TRL_WRITE);
      end
      ST_DBG_CTRL: begin
        xferA = 2'd1; xferWdata = PWR_UP_REQ; xferCount = CNT_W'(TRL_WRITE);
      end
      ST_SELECT: xferA = 2'd2;
      ST_CSW: begin xferApnDp = 1'b1; xferWdata = CSW_WORD32; end
      ST_TAR: begin xferApnDp = 1'b1; xferA = 2'd1; xferWdata = addrReg; end
      ST_DRW_WR: begin
        xferApnDp = 1'b1; xferA = 2'd3; xferWdata = wdataReg;
        xferCount = CNT_W'(TRL_WRITE);
      end
      ST_RDBUFF: begin xferRnw = 1'b1; xferA = 2'd3; xferCount = CNT_W'(TRL_READ); end
      ST_DRW_RD: begin
        xferApnDp = 1'b1; xferRnw = 1'b1; xferA = 2'd3;
        xferCount = CNT_W'(TRL_READ);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/swd_mem_seq.sv
module swd_mem_seq
  import swd_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [31:0]      cmdAddr,
  input  logic [31:0]      cmdWdata,
  input  logic [LEN_W-1:0] cmdLen,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic             opDone,
  output logic             opError,
  output logic             xferStart,
  output logic [1:0]       xferKind,
  output logic             xferApnDp,
  output logic             xferRnw,
  output logic [1:0]       xferA,
  output logic [31:0]      xferWdata,
  output logic [CNT_W-1:0] xferCount,
  input  logic             xferDone,
  input  logic [2:0]       xferAck,
  input  logic [31:0]      xferRdata
);

  step_t   step;
  strobe_t strb;
  logic    lenZero;
  logic    lenOne;
  logic    firstPending;

  swd_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .xferDone(xferDone), .xferAck(xferAck),
    .lenZero(lenZero), .lenOne(lenOne), .firstPending(firstPending),
    .cmdReady(cmdReady), .xferStart(xferStart),
    .opDone(opDone), .opError(opError), .step(step), .strb(strb)
  );

  swd_seq_dp #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .step(step),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdLen(cmdLen),
    .xferRdata(xferRdata),
    .lenZero(lenZero), .lenOne(lenOne), .firstPending(firstPending),
    .rdValid(rdValid), .rdData(rdData),
    .xferKind(xferKind), .xferApnDp(xferApnDp), .xferRnw(xferRnw),
    .xferA(xferA), .xferWdata(xferWdata), .xferCount(xferCount)
  );

endmodule

// File: rtl/swd_seq_chk.sv
module swd_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdReady,
  input logic             opDone,
  input logic             opError,
  input logic             xferStart,
  input logic [1:0]       xferKind,
  input logic             xferApnDp,
  input logic             xferRnw,
  input logic [1:0]       xferA,
  input logic [31:0]      xferWdata,
  input logic [CNT_W-1:0] xferCount,
  input logic             xferDone,
  input logic [2:0]       xferAck
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= 1'b0;
    else if (xferStart) outstanding <= 1'b1;
    else if (xferDone) outstanding <= 1'b0;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !xferStart); // R9

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart || (outstanding && !xferDone)) |=>
      ($stable(xferKind) && $stable(xferApnDp) && $stable(xferRnw) &&
       $stable(xferA) && $stable(xferWdata) && $stable(xferCount))); // R9

  AST_WAIT_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && xferDone && xferKind == 2'd0 && xferAck == 3'b010) |=>
      (xferStart && $stable(xferApnDp) && $stable(xferRnw) && $stable(xferA))); // R7

  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && xferDone && xferKind == 2'd0 &&
     xferAck != 3'b001 && xferAck != 3'b010) |=> (opDone && opError)); // R8

  AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    opError |-> opDone); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (cmdReady && !outstanding)); // R10

endmodule

bind swd_mem_seq swd_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .opDone(opDone),
  .opError(opError), .xferStart(xferStart), .xferKind(xferKind),
  .xferApnDp(xferApnDp), .xferRnw(xferRnw), .xferA(xferA),
  .xferWdata(xferWdata), .xferCount(xferCount), .xferDone(xferDone),
  .xferAck(xferAck)
);

// File: tb/swd_mem_seq_bench.sv
module swd_mem_seq_bench;

  typedef struct packed {
    logic [1:0]  kind;
    logic        ap;
    logic        rnw;
    logic [1:0]  a;
    logic [31:0] wd;
    logic [7:0]  cnt;
  } tx_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdWdata = '0;
  logic [7:0]  cmdLen = '0;
  logic        xferDone = 1'b0;
  logic [2:0]  xferAck = 3'b001;
  logic [31:0] xferRdata = '0;
  logic        cmdReady, rdValid, opDone, opError, xferStart;
  logic        xferApnDp, xferRnw;
  logic [1:0]  xferKind, xferA;
  logic [31:0] rdData, xferWdata;
  logic [7:0]  xferCount;

  swd_mem_seq u_swd_mem_seq (.*);

  always #4 clk = ~clk; // 125 MHz

  int    checks = 0;
  int    failures = 0;
  int    startCount = 0;
  int    rdSeq = 0;
  bit    discardPending = 0;
  string curReq = "R1";
  tx_t   expTx[$];
  logic [31:0] expWord[$];
  logic [2:0]  ackScript[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic tx_t mk(input logic [1:0] k, input logic ap, input logic rnw,
                             input logic [1:0] a, input logic [31:0] wd,
                             input logic [7:0] c);
    tx_t t;
    t.kind = k; t.ap = ap; t.rnw = rnw; t.a = a; t.wd = wd; t.cnt = c;
    return t;
  endfunction

  function automatic bit txMatch(input tx_t got, input tx_t exp);
    if (got.kind != exp.kind || got.cnt != exp.cnt) return 0;
    if (exp.kind != 2'd0) return 1;
    if (got.ap != exp.ap || got.rnw != exp.rnw || got.a != exp.a) return 0;
    return exp.rnw || (got.wd == exp.wd);
  endfunction

  task automatic expSetup(input logic [31:0] addr);
    expTx.push_back(mk(0, 0, 0, 0, 32'h0000_001E, 7));
    expTx.push_back(mk(0, 0, 0, 2, 32'h0, 0));
    expTx.push_back(mk(0, 1, 0, 0, 32'h2300_0012, 0));
    expTx.push_back(mk(0, 1, 0, 1, addr, 0));
  endtask

  task automatic expDrwRead(input int n);
    for (int i = 0; i < n; i++) expTx.push_back(mk(0, 1, 1, 3, 32'h0, 3));
  endtask

  task automatic waitDoneAndDrain(input bit expErr, input string req);
    while (!opDone) @(negedge clk);
    check(opError == expErr, req, "opError at done", 64'(opError), 64'(expErr));
    @(negedge clk);
    check(expTx.size() == 0, req, "transfers left unissued", 64'(expTx.size()), 64'd0);
    check(expWord.size() == 0, req, "words not produced", 64'(expWord.size()), 64'd0);
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] wd, input logic [7:0] len,
                       input bit expErr, input string req);
    curReq = req;
    @(negedge clk);
    check(cmdReady, req, "cmdReady before command", 64'(cmdReady), 64'd1);
    cmdOp = op; cmdAddr = addr; cmdWdata = wd; cmdLen = len; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    waitDoneAndDrain(expErr, req);
  endtask

  // Engine model and scoreboard monitor
  tx_t  capTx;
  bit   busyM = 0;
  bit   stableErr = 0;
  int   latCnt = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      busyM = 0; xferDone = 1'b0;
    end else begin
      if (xferDone) begin xferDone = 1'b0; busyM = 0; end
      if (busyM) begin
        if (xferStart) check(0, "R9", "start while a job is outstanding", 64'd1, 64'd0);
        if (mk(xferKind, xferApnDp, xferRnw, xferA, xferWdata, xferCount) != capTx)
          stableErr = 1;
        if (latCnt == 0) begin
          xferAck = (ackScript.size() != 0) ? ackScript.pop_front() : 3'b001;
          xferRdata = 32'h5EED_0000 + 32'(rdSeq);
          if (capTx.kind == 2'd0 && capTx.ap && capTx.rnw && capTx.a == 2'd3) begin
            rdSeq++;
            if (xferAck == 3'b001) begin
              if (discardPending) discardPending = 0; // R6 first read dropped
              else expWord.push_back(xferRdata);
            end
          end
          check(!stableErr, "R9", "job fields changed while outstanding", 64'(stableErr), 64'd0);
          xferDone = 1'b1;
        end else latCnt--;
      end else if (xferStart) begin
        startCount++;
        capTx = mk(xferKind, xferApnDp, xferRnw, xferA, xferWdata, xferCount);
        if (expTx.size() == 0)
          check(0, curReq, "unexpected transfer", 64'(capTx), 64'd0);
        else begin
          tx_t e;
          e = expTx.pop_front();
          check(txMatch(capTx, e), curReq, "transfer order/fields", 64'(capTx), 64'(e));
        end
        busyM = 1; latCnt = 2; stableErr = 0;
      end
      if (rdValid) begin
        if (expWord.size() == 0)
          check(0, "R6", "unexpected read word", 64'(rdData), 64'd0);
        else begin
          logic [31:0] w;
          w = expWord.pop_front();
          check(rdData == w, "R6", "read word", 64'(rdData), 64'(w));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdReady == 1'b1, "R1", "cmdReady", 64'(cmdReady), 64'd1);
    check(xferStart == 1'b0, "R1", "xferStart", 64'(xferStart), 64'd0);
    check(rdValid == 1'b0, "R1", "rdValid", 64'(rdValid), 64'd0);
    check(opDone == 1'b0, "R1", "opDone", 64'(opDone), 64'd0);

    // R2 connect
    expTx.push_back(mk(1, 0, 0, 0, 0, 56));
    expTx.push_back(mk(1, 0, 0, 0, 0, 59));
    expTx.push_back(mk(1, 0, 0, 0, 0, 59));
    expTx.push_back(mk(2, 0, 0, 0, 0, 16));
    expTx.push_back(mk(0, 0, 1, 0, 0, 6));
    runOp(2'd0, 32'h0, 32'h0, 8'd0, 1'b0, "R2");

    // R3 debug power-up
    expTx.push_back(mk(0, 0, 0, 0, 32'h0000_001E, 7));
    expTx.push_back(mk(0, 0, 0, 1, 32'h5000_0000, 7));
    runOp(2'd1, 32'h0, 32'h0, 8'd0, 1'b0, "R3");

    // R4 memory write
    expSetup(32'h2000_0010);
    expTx.push_back(mk(0, 1, 0, 3, 32'hCAFE_F00D, 7));
    expTx.push_back(mk(0, 0, 1, 3, 0, 3));
    runOp(2'd2, 32'h2000_0010, 32'hCAFE_F00D, 8'd0, 1'b0, "R4");

    // R5 / R6 read burst of three words: four data reads
    expSetup(32'h1000_0100);
    expDrwRead(4);
    discardPending = 1;
    runOp(2'd3, 32'h1000_0100, 32'h0, 8'd3, 1'b0, "R5");

    // R7 WAIT on setup and inside the burst
    expSetup(32'h1000_0200);
    expTx.insert(3, mk(0, 1, 0, 0, 32'h2300_0012, 0)); // CSW repeated
    expDrwRead(5);
    ackScript = '{3'b001, 3'b001, 3'b010, 3'b001, 3'b001,
                  3'b010, 3'b001, 3'b010, 3'b001, 3'b001};
    discardPending = 1;
    runOp(2'd3, 32'h1000_0200, 32'h0, 8'd2, 1'b0, "R7");

    // R8 FAULT on third data read ends a four-word burst after one word
    expSetup(32'h1000_0300);
    expDrwRead(3);
    ackScript = '{3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b100};
    discardPending = 1;
    runOp(2'd3, 32'h1000_0300, 32'h0, 8'd4, 1'b1, "R8");
    begin
      int s0;
      s0 = startCount;
      repeat (10) @(negedge clk);
      check(startCount == s0, "R8", "jobs after fault", 64'(startCount), 64'(s0));
    end

    // R11 zero-length burst
    expSetup(32'h1000_0400);
    discardPending = 1;
    runOp(2'd3, 32'h1000_0400, 32'h0, 8'd0, 1'b0, "R11");

    // R10 command while busy is ignored
    curReq = "R10";
    expSetup(32'h3000_0000);
    expTx.push_back(mk(0, 1, 0, 3, 32'h1234_5678, 7));
    expTx.push_back(mk(0, 0, 1, 3, 0, 3));
    @(negedge clk);
    cmdOp = 2'd2; cmdAddr = 32'h3000_0000; cmdWdata = 32'h1234_5678; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (6) @(negedge clk);
    check(cmdReady == 1'b0, "R10", "cmdReady while busy", 64'(cmdReady), 64'd0);
    cmdOp = 2'd0; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    waitDoneAndDrain(1'b0, "R10");
    begin
      int s1;
      s1 = startCount;
      repeat (20) @(negedge clk);
      check(startCount == s1, "R10", "jobs from ignored command", 64'(startCount), 64'(s1));
      check(cmdReady == 1'b1, "R10", "cmdReady after done", 64'(cmdReady), 64'd1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule